// File: doc/BRIEF.md
# Bubble-Shifted Latch Delay Line

This block delays a serial bit stream by a fixed number of clock cycles (502 by default) using storage cells that act like level-sensitive latches. Each cell is written only while its enable is high, and it takes no part in a clock tree of its own. The stream is dealt out in rotation to eight lanes. Each lane therefore moves at one eighth of the bit rate. A collecting multiplexer merges the lanes back into one serial output.

Inside a lane, the cells are arranged in groups of four. One cell in each group is always a vacant duplicate, so a group holds three distinct bits. Four non-overlapping slot enables open one cell position at a time, working backward from the output end. Each opened cell copies its predecessor, and the vacancy walks toward the input.

An external sequencer supplies the lane counter and the slot enable. The block has no phase generation of its own. The total delay is 24 cycles per group plus a fixed 5 cycles, and the remainder is made up by a short trailing register chain.

Top module: `bubble_delay_line`

## Requirements
- R1: With DELAY=502, the value on `dout` in cycle t+502 equals the value on `din` in cycle t, for every input pattern, provided no reset occurred in between.
- R2: Lane l captures `din` in the cycle where `lane_sel` equals l. The output register reads the lane numbered `lane_sel` XOR 4, so all eight lanes see the same end-to-end delay.
- R3: `shift_pulse` is one-hot, and bit s opens slot s. In a cycle with lane counter value n, the slot opened is 3 - n[2:1]. The slot fires in the four lanes whose lowest index bit equals n[0].
- R4: `lane_sel` advances by exactly one, modulo 8, every cycle.
- R5: Each lane has DELAY/24 groups of four cells (20 at the default). When a cell has fired, it equals its predecessor on the next cycle, so a group keeps three distinct bits and contributes 24 cycles. The leftover delay (17 at the default) is made up by trailing stages.
- R6: Reset is synchronous and active high. It clears every cell, the lane capture registers and the output chain, so `dout` is 0 in the cycle after reset is sampled.
- R7: After reset is released, `dout` stays 0 for the first 502 cycles, whatever `din` carries. The first bit presented after release appears exactly 502 cycles later.
- R8: A bit presented while reset is high is discarded. So is any bit still in flight when reset arrives: `dout` shows 0 at the time such a bit would have left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data in |
| lane_sel | input | 3 | Rotating lane counter from the sequencer |
| shift_pulse | input | 4 | One-hot slot enable, bit s opens cell slot s |
| dout | output | 1 | Serial data out, registered |

## Verification
The stream is tried with a long run of ones straight after reset, which pins down the exact arrival cycle of the first bit and shows that the line starts empty. It is also tried with a single isolated one placed on each of the eight lanes in turn, which exposes any lane whose delay differs or whose index is swapped. Alternating, period-8 and period-7 patterns follow. They tell apart lane mixing, slot ordering and a group that holds too many or too few bits. A random stream and a reset in the middle of a random stream complete the set. The mid-stream reset shows that bits in flight, and bits presented during reset, never reach the output.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  // lane count and slot count are fixed by the slot schedule (2 cycles per slot)
  localparam int LANES     = 8;
  localparam int LANE_W    = $clog2(LANES);
  localparam int SLOTS     = 4;
  // one group moves a bit through (SLOTS-1) lane rounds of LANES cycles
  localparam int GROUP_CYC = (SLOTS - 1) * LANES;
  // entry wait, output pick and output register around the lanes
  localparam int FIXED_LAT = 5;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [SLOTS-1:0]  slot_t;
endpackage

// File: rtl/bsl_demux.sv
module bsl_demux
  import bsl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  lane_t            lane_sel,
  output logic [LANES-1:0] lane_in
);
  // each lane keeps the bit offered in its own slot of the rotation
  for (genvar l = 0; l < LANES; l++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)
        lane_in[l] <= 1'b0;
      else if (lane_sel == lane_t'(l))
        lane_in[l] <= din;
    end
  end
endmodule

// File: rtl/bsl_lane.sv
module bsl_lane
  import bsl_pkg::*;
#(
  parameter int GROUPS = 20
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  fire,
  input  slot_t slot,
  input  logic  ser_in,
  output logic  ser_out
);
  localparam int CELLS = GROUPS * SLOTS;

  logic [CELLS-1:0] cell_q;
  logic [CELLS-1:0] pred;
  logic [CELLS-1:0] en;

  // every cell copies the one behind it; cell 0 takes the lane input
  assign pred = {cell_q[CELLS-2:0], ser_in};
  // the same slot position opens in every group of this lane
  assign en   = fire ? {GROUPS{slot}} : '0;

  always_ff @(posedge clk) begin
    if (rst)
      cell_q <= '0;
    else
      cell_q <= (en & pred) | (~en & cell_q);
  end

  assign ser_out = cell_q[CELLS-1];

  // a fired cell and its predecessor form the vacant duplicate pair
  for (genvar j = 1; j < CELLS; j++) begin : g_chk
    // R5
    bubble_dup_chk: assert property (@(posedge clk) disable iff (rst)
      (fire && slot[j % SLOTS]) |=> (cell_q[j] == cell_q[j-1]));
  end
endmodule

// File: rtl/bsl_collect.sv
module bsl_collect
  import bsl_pkg::*;
#(
  parameter int TAIL = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_out,
  input  lane_t            lane_sel,
  output logic             dout
);
  localparam lane_t HALF = lane_t'(LANES / 2);

  logic mux_q;

  // read the lane whose data window is centred half a rotation later
  always_ff @(posedge clk) begin
    if (rst)
      mux_q <= 1'b0;
    else
      mux_q <= lane_out[lane_sel ^ HALF];
  end

  if (TAIL == 0) begin : g_direct
    assign dout = mux_q;
  end else begin : g_tail
    logic [TAIL-1:0] tail_q;
    always_ff @(posedge clk) begin
      if (rst)
        tail_q <= '0;
      else begin
        tail_q[0] <= mux_q;
        for (int k = 1; k < TAIL; k++)
          tail_q[k] <= tail_q[k-1];
      end
    end
    assign dout = tail_q[TAIL-1];
  end
endmodule

// File: rtl/bubble_delay_line.sv
module bubble_delay_line
  import bsl_pkg::*;
#(
  parameter int DELAY = 502
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [LANE_W-1:0] lane_sel,
  input  logic [SLOTS-1:0]  shift_pulse,
  output logic              dout
);
  // DELAY must be at least GROUP_CYC + FIXED_LAT
  localparam int GROUPS = (DELAY - FIXED_LAT) / GROUP_CYC;
  localparam int TAIL   = DELAY - FIXED_LAT - GROUPS * GROUP_CYC;

  logic [LANES-1:0] lane_in;
  logic [LANES-1:0] lane_out;
  logic [LANES-1:0] fire;

  bsl_demux u_demux (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .lane_sel (lane_sel),
    .lane_in  (lane_in)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // even and odd lanes take turns, so one pulse reaches an eighth of the cells
    assign fire[l] = (lane_sel[0] == 1'(l % 2));

    bsl_lane #(.GROUPS(GROUPS)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .fire    (fire[l]),
      .slot    (shift_pulse),
      .ser_in  (lane_in[l]),
      .ser_out (lane_out[l])
    );
  end

  bsl_collect #(.TAIL(TAIL)) u_collect (
    .clk      (clk),
    .rst      (rst),
    .lane_out (lane_out),
    .lane_sel (lane_sel),
    .dout     (dout)
  );

  // R3
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(shift_pulse));

  // R3
  pulse_sched_chk: assert property (@(posedge clk) disable iff (rst)
    shift_pulse == ((slot_t'(1) << (SLOTS - 1)) >> lane_sel[LANE_W-1:1]));

  // R4
  lane_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> lane_sel == lane_t'($past(lane_sel) + 1'b1));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> dout == 1'b0);
endmodule

// File: tb/bubble_delay_line_test.sv
module bubble_delay_line_test;
  localparam int CLK_PERIOD = 10;
  localparam int DELAY      = 502;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [2:0] lane_sel = 3'd0;
  logic [3:0] shift_pulse = 4'b1000;
  logic       dout;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit armed  = 1'b0;
  logic [DELAY-1:0] hist = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bubble_delay_line #(.DELAY(DELAY)) uut (
    .clk         (clk),
    .rst         (rst),
    .din         (din),
    .lane_sel    (lane_sel),
    .shift_pulse (shift_pulse),
    .dout        (dout)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  // one cycle: check the current output against the model, then drive the next inputs
  task automatic tick(input logic d, input logic r, input string tag);
    logic [2:0] nxt;
    @(negedge clk);
    if (armed) begin
      checks++;
      if (dout !== hist[DELAY-1]) begin
        fails++;
        $display("FAIL %s: dout=%b expected %b at cycle %0d", tag, dout, hist[DELAY-1], cyc);
      end
    end
    nxt         = lane_sel + 3'd1;
    lane_sel    = nxt;                 // R4 schedule
    shift_pulse = 4'b1000 >> nxt[2:1]; // R3 schedule
    rst         = r;
    din         = d;
    hist        = r ? '0 : {hist[DELAY-2:0], d};
    if (r) armed = 1'b1;
    cyc++;
  endtask

  task automatic t_reset_state();
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, "R6 reset clears output");
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, "R6 output zero after reset");
  endtask

  task automatic t_flush_ones();
    tick(1'b1, 1'b1, "R6 reset before flush");
    for (int i = 0; i < DELAY; i++) tick(1'b1, 1'b0, "R7 empty line after release");
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, "R1 first ones arrive on time");
  endtask

  task automatic t_single_lane();
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < DELAY; i++) tick(1'b0, 1'b0, "R2 clear before lane probe");
      while (lane_sel != 3'(k - 1)) tick(1'b0, 1'b0, "R2 align to lane");
      tick(1'b1, 1'b0, "R2 lone bit on one lane");
      for (int i = 0; i < DELAY + 8; i++) tick(1'b0, 1'b0, "R2 lone bit per lane");
    end
  endtask

  task automatic t_patterns();
    for (int i = 0; i < DELAY + 100; i++) tick(1'(i % 2), 1'b0, "R1 R3 alternating");
    for (int i = 0; i < DELAY + 100; i++) tick(1'((i / 4) % 2), 1'b0, "R1 R5 period eight");
    for (int i = 0; i < DELAY + 100; i++) tick(1'((i % 7) < 3), 1'b0, "R1 R4 period seven");
  endtask

  task automatic t_random();
    for (int i = 0; i < 3000; i++) tick(1'($urandom % 2), 1'b0, "R1 R5 random stream");
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 300; i++) tick(1'($urandom % 2), 1'b0, "R1 before mid reset");
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, "R8 bits during reset dropped");
    for (int i = 0; i < DELAY + 20; i++) tick(1'b0, 1'b0, "R8 in-flight bits dropped");
    for (int i = 0; i < 200; i++) tick(1'($urandom % 2), 1'b0, "R1 after mid reset");
  endtask

  initial begin
    void'($urandom(7));
    t_reset_state();
    t_flush_ones();
    t_single_lane();
    t_patterns();
    t_random();
    t_mid_reset();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1: run hung, actual cycle %0d expected completion", cyc);
    summary();
    $finish;
  end
endmodule